// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is one output cell of a small programmable logic array. It receives the results of its own product terms and of product terms borrowed from neighbouring cells that do not use them. It ORs the enabled terms into one sum, applies a programmable inversion, and then either passes that value straight out or stores it in a state bit. The state bit can act as a D, T, JK or SR flip-flop. Configuration arrives as static input bits.

The state bit has a clock that can be chosen: either every edge of the global clock, or a rising edge of a product-term clock sampled on the global clock. A clear term and a preset term override the state at once. A host port can load the state bit directly and can read its value back. The chosen cell value drives the pin path and also returns to the array as feedback. A separate product term drives the pin's output enable.

Top module: `omc_cell`

## Requirements
- R1: The sum is the OR of all native term inputs together with each borrowed term input whose enable bit is 1. A borrowed term whose enable bit is 0 has no effect.
- R2: The adjusted value equals the sum XOR `cfg_inv`.
- R3: When `cfg_reg`=0, `pin_out` and `fb_out` carry the adjusted value combinationally. When `cfg_reg`=1, they carry the state bit. `pin_oe` always follows `pt_oe`.
- R4: With `cfg_mode`=0 (D), a clock event stores the adjusted value.
- R5: With `cfg_mode`=1 (T), a clock event inverts the state when the adjusted value is 1.
- R6: With `cfg_mode`=2 (JK), J is the adjusted value and K is `pt_k`. J,K = 00 holds, 01 clears, 10 sets and 11 toggles.
- R7: With `cfg_mode`=3 (SR), S is the adjusted value and R is `pt_k`. 00 holds, 01 clears, 10 sets, and 11 holds the current state.
- R8: With `cfg_clk_pt`=0, every rising `gclk` edge is a clock event. With `cfg_clk_pt`=1, a clock event happens only at a `gclk` edge where `pt_clk` is 1 and was 0 at the previous `gclk` edge. Without a clock event the state does not change.
- R9: `pt_clr`=1 forces the state seen at `host_q` to 0 in the same cycle, and `pt_pre`=1 forces it to 1. Clear wins over preset. The forced value is stored at the next `gclk` edge, and any pending host load is dropped.
- R10: `host_wr`=1 requests that `host_din` be loaded. At a clock event the load replaces the flip-flop logic. A request that arrives without a clock event is held and applied at the next clock event.
- R11: `host_q` always shows the state bit after any clear or preset override, in every mode.
- R12: While `rst_n`=0 the state, the pending load and the product-term clock history are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_borrow_en | input | NB | Enable per borrowed term |
| cfg_inv | input | 1 | Polarity inversion |
| cfg_mode | input | 2 | Flip-flop mode: 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_pt | input | 1 | 1 selects the product-term clock |
| cfg_reg | input | 1 | 1 selects the registered output |
| pt_native | input | NN | Native product terms |
| pt_borrow | input | NB | Borrowed product terms |
| pt_k | input | 1 | Second logic input (K or R) |
| pt_clk | input | 1 | Product-term clock |
| pt_pre | input | 1 | Preset term |
| pt_clr | input | 1 | Clear term |
| pt_oe | input | 1 | Output-enable term |
| host_wr | input | 1 | Host load strobe |
| host_din | input | 1 | Host load data |
| host_q | output | 1 | Host readback of the state |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
A wrong state bit shows up on `host_q` in the cycle after the clock event that stored it. When `cfg_reg` is 1, it also shows on `pin_out` and `fb_out` in that cycle. A lost or stuck pending host load stays hidden until the next product-term clock edge, so the bench holds `pt_clk` low across write strobes and then raises it. A mistake in the clear or preset priority shows without any clock, within the same cycle. The reference model steps every mode, both clock sources and both output selections under random terms, and it compares all outputs in every cycle.

// File: rtl/omc_pkg.sv
package omc_pkg;
    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_mode_e;

    typedef struct packed {
        logic q;
        logic pend;
        logic pend_d;
    } ff_state_t;
endpackage

// File: rtl/omc_sum.sv
module omc_sum #(
    parameter int NN = 4,
    parameter int NB = 3
) (
    input  logic [NN-1:0] native_i,
    input  logic [NB-1:0] borrow_i,
    input  logic [NB-1:0] borrow_en_i,
    input  logic          inv_i,
    output logic          adj_o
);
    logic [NB-1:0] gated;
    logic          sum;

    for (genvar i = 0; i < NB; i++) begin : g_borrow
        assign gated[i] = borrow_i[i] & borrow_en_i[i];
    end

    always_comb begin
        sum   = (|native_i) | (|gated);
        adj_o = sum ^ inv_i;
    end
endmodule

// File: rtl/omc_clk_edge.sv
module omc_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_pt_i,
    input  logic pt_clk_i,
    output logic event_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = pt_clk_i;
        event_o = sel_pt_i ? (pt_clk_i & ~prev_q) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/omc_state.sv
module omc_state
    import omc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     event_i,
    input  ff_mode_e mode_i,
    input  logic     d_i,
    input  logic     k_i,
    input  logic     clr_i,
    input  logic     pre_i,
    input  logic     wr_i,
    input  logic     din_i,
    output logic     q_o
);
    ff_state_t st_d, st_q;
    logic      logic_nx;

    always_comb begin
        unique case (mode_i)
            FF_D:  logic_nx = d_i;
            FF_T:  logic_nx = st_q.q ^ d_i;
            FF_JK: begin
                unique case ({d_i, k_i})
                    2'b00:   logic_nx = st_q.q;
                    2'b01:   logic_nx = 1'b0;
                    2'b10:   logic_nx = 1'b1;
                    default: logic_nx = ~st_q.q;
                endcase
            end
            default: begin
                unique case ({d_i, k_i})
                    2'b01:   logic_nx = 1'b0;
                    2'b10:   logic_nx = 1'b1;
                    default: logic_nx = st_q.q;
                endcase
            end
        endcase

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (pre_i) begin
            st_d.q      = 1'b1;
            st_d.pend   = 1'b0;
            st_d.pend_d = 1'b0;
        end else if (event_i) begin
            st_d.pend   = 1'b0;
            st_d.pend_d = 1'b0;
            if (wr_i)           st_d.q = din_i;
            else if (st_q.pend) st_d.q = st_q.pend_d;
            else                st_d.q = logic_nx;
        end else if (wr_i) begin
            st_d.pend   = 1'b1;
            st_d.pend_d = din_i;
        end

        q_o = st_q.q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    clr_stores_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);

    // R9
    pre_stores_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !clr_i) |=> q_o);

    // R8
    no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_i && !clr_i && !pre_i) |=> (q_o == $past(q_o)));

    // R10
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && wr_i && !clr_i && !pre_i) |=> (q_o == $past(din_i)));

    // R4
    d_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == FF_D && event_i && !wr_i && !st_q.pend && !clr_i && !pre_i)
        |=> (q_o == $past(d_i)));

    // R6
    jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == FF_JK && event_i && d_i && k_i && !wr_i && !st_q.pend
         && !clr_i && !pre_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/omc_cell.sv
module omc_cell
    import omc_pkg::*;
#(
    parameter int NN = 4,
    parameter int NB = 3
) (
    input  logic          gclk,
    input  logic          rst_n,
    input  logic [NB-1:0] cfg_borrow_en,
    input  logic          cfg_inv,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_clk_pt,
    input  logic          cfg_reg,
    input  logic [NN-1:0] pt_native,
    input  logic [NB-1:0] pt_borrow,
    input  logic          pt_k,
    input  logic          pt_clk,
    input  logic          pt_pre,
    input  logic          pt_clr,
    input  logic          pt_oe,
    input  logic          host_wr,
    input  logic          host_din,
    output logic          host_q,
    output logic          pin_out,
    output logic          pin_oe,
    output logic          fb_out
);
    logic     adj;
    logic     clk_event;
    logic     ff_q;
    logic     q_eff;
    logic     cell_val;
    ff_mode_e mode;

    assign mode = ff_mode_e'(cfg_mode);

    omc_sum #(.NN(NN), .NB(NB)) u_sum (
        .native_i    (pt_native),
        .borrow_i    (pt_borrow),
        .borrow_en_i (cfg_borrow_en),
        .inv_i       (cfg_inv),
        .adj_o       (adj)
    );

    omc_clk_edge u_edge (
        .clk      (gclk),
        .rst_n    (rst_n),
        .sel_pt_i (cfg_clk_pt),
        .pt_clk_i (pt_clk),
        .event_o  (clk_event)
    );

    omc_state u_state (
        .clk     (gclk),
        .rst_n   (rst_n),
        .event_i (clk_event),
        .mode_i  (mode),
        .d_i     (adj),
        .k_i     (pt_k),
        .clr_i   (pt_clr),
        .pre_i   (pt_pre),
        .wr_i    (host_wr),
        .din_i   (host_din),
        .q_o     (ff_q)
    );

    always_comb begin
        if (pt_clr)      q_eff = 1'b0;
        else if (pt_pre) q_eff = 1'b1;
        else             q_eff = ff_q;
        cell_val = cfg_reg ? q_eff : adj;
        host_q   = q_eff;
        pin_out  = cell_val;
        fb_out   = cell_val;
        pin_oe   = pt_oe;
    end

    // R9
    clr_beats_pre_chk: assert property (@(posedge gclk) disable iff (!rst_n)
        (pt_clr && pt_pre) |-> !host_q);
endmodule

// File: tb/omc_cell_tb.sv
`timescale 1ns/1ps
module omc_cell_tb;
    localparam int NN = 4;
    localparam int NB = 3;

    logic          gclk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] cfg_borrow_en = '0;
    logic          cfg_inv = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_clk_pt = 1'b0;
    logic          cfg_reg = 1'b0;
    logic [NN-1:0] pt_native = '0;
    logic [NB-1:0] pt_borrow = '0;
    logic          pt_k = 1'b0, pt_clk = 1'b0, pt_pre = 1'b0, pt_clr = 1'b0, pt_oe = 1'b0;
    logic          host_wr = 1'b0, host_din = 1'b0;
    logic          host_q, pin_out, pin_oe, fb_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    bit  m_q = 1'b0, m_pend = 1'b0, m_pend_d = 1'b0, m_prev = 1'b0;

    always #4 gclk = ~gclk;

    omc_cell #(.NN(NN), .NB(NB)) u_dut (
        .gclk(gclk), .rst_n(rst_n), .cfg_borrow_en(cfg_borrow_en), .cfg_inv(cfg_inv),
        .cfg_mode(cfg_mode), .cfg_clk_pt(cfg_clk_pt), .cfg_reg(cfg_reg),
        .pt_native(pt_native), .pt_borrow(pt_borrow), .pt_k(pt_k), .pt_clk(pt_clk),
        .pt_pre(pt_pre), .pt_clr(pt_clr), .pt_oe(pt_oe), .host_wr(host_wr),
        .host_din(host_din), .host_q(host_q), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_out(fb_out)
    );

    function automatic bit exp_adj();
        bit s = 1'b0;
        for (int i = 0; i < NN; i++) s = s | pt_native[i];
        for (int i = 0; i < NB; i++) s = s | (pt_borrow[i] & cfg_borrow_en[i]);
        return s ^ cfg_inv;
    endfunction

    function automatic bit exp_state();
        if (pt_clr) return 1'b0;
        if (pt_pre) return 1'b1;
        return m_q;
    endfunction

    function automatic bit next_logic(bit a);
        case (cfg_mode)
            2'd0: return a;
            2'd1: return m_q ^ a;
            2'd2: begin
                if (a && pt_k) return ~m_q;
                if (a) return 1'b1;
                if (pt_k) return 1'b0;
                return m_q;
            end
            default: begin
                if (a && !pt_k) return 1'b1;
                if (!a && pt_k) return 1'b0;
                return m_q;
            end
        endcase
    endfunction

    // Model of one global clock edge with the inputs currently held.
    task automatic model_edge();
        bit ev;
        bit nq;
        if (!rst_n) begin
            m_q = 0; m_pend = 0; m_pend_d = 0; m_prev = 0;
            return;
        end
        ev = cfg_clk_pt ? (pt_clk && !m_prev) : 1'b1;
        nq = next_logic(exp_adj());
        if (pt_clr) begin
            m_q = 0; m_pend = 0;
        end else if (pt_pre) begin
            m_q = 1; m_pend = 0;
        end else if (ev) begin
            if (host_wr) m_q = host_din;
            else if (m_pend) m_q = m_pend_d;
            else m_q = nq;
            m_pend = 0;
        end else if (host_wr) begin
            m_pend = 1; m_pend_d = host_din;
        end
        m_prev = pt_clk;
    endtask

    task automatic chk(string tag);
        bit eq  = exp_state();
        bit ec  = cfg_reg ? eq : exp_adj();
        n_checks++;
        if (host_q !== eq || pin_out !== ec || fb_out !== ec || pin_oe !== pt_oe) begin
            n_errors++;
            $display("FAIL %s: q/pin/fb/oe got %b%b%b%b exp %b%b%b%b", tag,
                     host_q, pin_out, fb_out, pin_oe, eq, ec, ec, pt_oe);
        end
    endtask

    task automatic tick(string tag);
        @(posedge gclk);
        @(negedge gclk);
        model_edge();
        chk(tag);
    endtask

    task automatic quiet();
        pt_native = '0; pt_borrow = '0; pt_k = 0; pt_pre = 0; pt_clr = 0;
        host_wr = 0; host_din = 0; pt_clk = 0;
    endtask

    function automatic string mtag();
        case (cfg_mode)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge gclk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge gclk);
        cfg_reg = 1; pt_oe = 1;
        #1 chk("R12 reset state");
        rst_n = 1;
        tick("R12 after release");

        // R1 borrowed term gated by enable, R2 polarity, R3 combinational path
        cfg_reg = 0; pt_borrow = '1; cfg_borrow_en = '0;
        #1 chk("R1 disabled borrow ignored");
        cfg_borrow_en = 3'b010;
        #1 chk("R1 enabled borrow");
        cfg_inv = 1;
        #1 chk("R2 inverted");
        pt_oe = 0;
        #1 chk("R3 oe follows term");
        cfg_inv = 0; pt_borrow = '0; cfg_borrow_en = '0; pt_oe = 1;

        // R10 host load beats logic in global clock mode
        cfg_reg = 1; cfg_mode = 2'd0; pt_native = 4'b0001;
        host_wr = 1; host_din = 0;
        tick("R10 load beats D input");
        quiet();
        tick("R4 D stores zero");

        // R9 clear beats preset, immediate and stored
        pt_native = 4'b0001; tick("R4 D stores one");
        pt_clr = 1; pt_pre = 1;
        #1 chk("R9 clear over preset immediate");
        tick("R9 clear stored");
        pt_clr = 0; pt_pre = 0; pt_native = '0; cfg_mode = 2'd1;
        #1 chk("R9 cleared value held");
        pt_pre = 1;
        #1 chk("R11 preset visible on readback");
        tick("R9 preset stored");
        pt_pre = 0;
        #1 chk("R9 preset value held");

        // R8 / R10 pending load in product-term clock mode
        cfg_clk_pt = 1; cfg_mode = 2'd0; pt_clk = 0;
        host_wr = 1; host_din = 0;
        tick("R10 no event write deferred");
        host_wr = 0; host_din = 1; pt_native = 4'b1000;
        tick("R8 no event state held");
        pt_clk = 1;
        tick("R10 pending applied at pt edge");
        tick("R8 held pt_clk high no event");
        pt_clk = 0; tick("R8 pt_clk low");
        pt_clk = 1; tick("R4 D at pt edge");

        // R6 JK all input pairs, R7 SR hold on 11
        quiet(); cfg_clk_pt = 0; cfg_mode = 2'd2;
        for (int j = 0; j < 4; j++) begin
            pt_native = {3'b0, j[1]}; pt_k = j[0];
            tick("R6 JK pair");
            tick("R6 JK pair repeat");
        end
        cfg_mode = 2'd3; pt_native = 4'b0001; pt_k = 1;
        tick("R7 SR 11 holds");
        pt_native = '0; tick("R7 SR reset");
        pt_native = 4'b0001; pt_k = 1; tick("R7 SR 11 holds zero");

        // Random sweep over every mode, clock source and output selection
        for (int cfg = 0; cfg < 16; cfg++) begin
            quiet();
            cfg_mode = cfg[1:0]; cfg_clk_pt = cfg[2]; cfg_reg = cfg[3];
            cfg_borrow_en = NB'($urandom); cfg_inv = 1'($urandom);
            for (int c = 0; c < 400; c++) begin
                pt_native = NN'((($urandom % 3) == 0) ? $urandom : 0);
                pt_borrow = NB'($urandom);
                pt_k      = 1'($urandom);
                pt_clk    = 1'($urandom);
                pt_oe     = 1'($urandom);
                pt_clr    = (($urandom % 16) == 0);
                pt_pre    = (($urandom % 16) == 0);
                host_wr   = (($urandom % 8) == 0);
                host_din  = 1'($urandom);
                #1 chk(cfg[3] ? "R11 random comb view" : "R3 random comb view");
                tick(cfg[2] ? $sformatf("%s R8 random", mtag()) : mtag());
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule